// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block is the purely combinational data path of a small accumulator machine. Each cycle the surrounding core presents an operation code, one or two operand words (usually the accumulator and either the B register or another source) and the current carry, auxiliary-carry and overflow flags. The unit returns a primary result word, a secondary result word that multiply and divide use to fill the B register, a result-write strobe and the next values of the three flags.

The operations cover addition with and without carry-in, subtraction with borrow, increment, decrement, an unsigned compare that only touches carry, an unsigned multiply with a double-width product, an unsigned divide, a decimal adjust for packed BCD sums, bitwise AND/OR/XOR, complement, single-bit rotates and a half-word swap. Flags that an operation does not define are passed through unchanged, so the core can always write the flag outputs back. The data width is a parameter (default 8, a multiple of 4), and the divider can be built either from the language operator or as an unrolled restoring array.

Top module: `acc_alu`

## Requirements
- R1: With op 0 (add) the result is (opa + opb) mod 2^W; with op 1 (add with carry) it is (opa + opb + cy_in) mod 2^W. cy_out is the carry out of the top bit, ac_out the carry out of bit 3 and ov_out is set when the two's-complement sum is out of range.
- R2: With op 2 (subtract with borrow) the result is (opa - opb - cy_in) mod 2^W. cy_out is set on a borrow out of the top bit, ac_out on a borrow out of bit 3 and ov_out on a two's-complement overflow.
- R3: Op 3 gives opa + 1 and op 4 gives opa - 1, both wrapping modulo 2^W, and all three flags equal their inputs.
- R4: With op 5 (compare) res_we is 0 and cy_out is 1 exactly when opa < opb as unsigned numbers. ac_out and ov_out equal their inputs.
- R5: With op 6 (multiply) the 2W-bit product opa*opb appears as {res_hi, res}. cy_out is 0, ov_out is 1 exactly when res_hi is nonzero, and ac_out equals ac_in.
- R6: With op 7 (divide) and opb nonzero, res is the unsigned quotient, res_hi the remainder, cy_out and ov_out are 0. With opb zero, ov_out is 1 and cy_out is 0, and the result words carry no defined value. ac_out equals ac_in in both cases.
- R7: With op 8 (decimal adjust) 6 is added to opa when its low nibble exceeds 9 or ac_in is set; 6 is then added to the top nibble when that intermediate top nibble exceeds 9, or cy_in is set, or the first step carried out. cy_out is cy_in OR either carry out; ac_out and ov_out equal their inputs.
- R8: Ops 9, 10, 11 and 12 give opa AND opb, opa OR opb, opa XOR opb and NOT opa, leaving all three flags equal to their inputs.
- R9: Op 13 rotates opa left by one bit, op 14 rotates it right by one bit and op 15 exchanges its upper and lower halves, with all three flags equal to their inputs.
- R10: res_we is 1 for every op other than 5, and res_hi is 0 for every op other than 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (0 to 15, see requirements) |
| opa | input | W | First operand, normally the accumulator |
| opb | input | W | Second operand |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| res | output | W | Primary result word |
| res_hi | output | W | Secondary result: product high word or remainder |
| res_we | output | 1 | Primary result should be written back |
| cy_out | output | 1 | Next carry flag |
| ac_out | output | 1 | Next auxiliary-carry flag |
| ov_out | output | 1 | Next overflow flag |

## Verification
The unit holds no state, so any fault in its internal nets shows at the ports in the same cycle the operands are applied: a wrong carry chain corrupts res or a flag for that vector alone, and no error can linger or hide until later. The bench therefore checks every output on every vector against a model built from integer arithmetic, mixing seeded random operands and flags with directed cases at the carry, borrow, signed-overflow, zero-divisor and BCD-adjust boundaries. Flag pass-through is checked by driving random incoming flags on operations that must not alter them.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDC = 4'd1,
      OP_SUBB = 4'd2,
      OP_INC  = 4'd3,
      OP_DEC  = 4'd4,
      OP_CMP  = 4'd5,
      OP_MUL  = 4'd6,
      OP_DIV  = 4'd7,
      OP_DA   = 4'd8,
      OP_AND  = 4'd9,
      OP_OR   = 4'd10,
      OP_XOR  = 4'd11,
      OP_CPL  = 4'd12,
      OP_RL   = 4'd13,
      OP_RR   = 4'd14,
      OP_SWAP = 4'd15
   } alu_op_e;

   localparam int NIB = 4;

endpackage

// File: rtl/acc_alu_adder.sv
// Add/subtract with nibble carry and signed overflow detection.
module acc_alu_adder #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         c_out,
   output logic         h_out,
   output logic         v_out
);
   import acc_alu_pkg::*;

   logic [W-1:0]   bx;
   logic           ci;
   logic [NIB:0]   lo;
   logic [W-1:0]   mid;
   logic [W:0]     full;

   always_comb begin
      bx   = sub ? ~b : b;
      ci   = sub ? ~cin : cin;
      lo   = {1'b0, a[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, ci};
      mid  = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, ci};
      full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
      sum  = full[W-1:0];
      // Subtraction reports a borrow, the inverse of the adder carry.
      c_out = sub ? ~full[W] : full[W];
      h_out = sub ? ~lo[NIB] : lo[NIB];
      v_out = full[W] ^ mid[W-1];
   end

endmodule

// File: rtl/acc_alu_muldiv.sv
// Unsigned multiply and divide; DIV_IMPL picks the divider structure.
module acc_alu_muldiv #(
   parameter int W        = 8,
   parameter int DIV_IMPL = 1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prod_lo,
   output logic [W-1:0] prod_hi,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);
   localparam int W2 = 2 * W;

   logic [W2-1:0] prod;
   assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
   assign prod_lo = prod[W-1:0];
   assign prod_hi = prod[W2-1:W];

   generate
      if (DIV_IMPL == 0) begin : g_div_op
         // A zero divisor yields all-ones quotient and the dividend as remainder.
         assign quot = (b == '0) ? '1 : a / b;
         assign rem  = (b == '0) ? a  : a % b;
      end else begin : g_div_array
         logic [W:0]   part [0:W];
         logic [W-1:0] qbit;
         assign part[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_step
            logic [W:0] trial;
            logic       ge;
            assign trial        = {part[i][W-1:0], a[W-1-i]};
            assign ge           = trial >= {1'b0, b};
            assign part[i+1]    = ge ? trial - {1'b0, b} : trial;
            assign qbit[W-1-i]  = ge;
         end
         assign quot = qbit;
         assign rem  = part[W][W-1:0];
      end
   endgenerate

endmodule

// File: rtl/acc_alu_bcd.sv
// Decimal adjust of a packed BCD sum, applied to lowest and highest nibble.
module acc_alu_bcd #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic         cy_in,
   input  logic         ac_in,
   output logic [W-1:0] res,
   output logic         cy_out
);
   import acc_alu_pkg::*;

   localparam logic [W:0] FIX_LO = (W+1)'(6);
   localparam logic [W:0] FIX_HI = (W+1)'(6) << (W - NIB);

   logic         lo_fix;
   logic [W:0]   step1;
   logic         hi_fix;
   logic [W:0]   step2;

   always_comb begin
      lo_fix = (a[NIB-1:0] > 4'd9) || ac_in;
      step1  = {1'b0, a} + (lo_fix ? FIX_LO : '0);
      hi_fix = (step1[W-1:W-NIB] > 4'd9) || cy_in || step1[W];
      step2  = {1'b0, step1[W-1:0]} + (hi_fix ? FIX_HI : '0);
      res    = step2[W-1:0];
      cy_out = cy_in | step1[W] | step2[W];
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int W        = 8,
   parameter int DIV_IMPL = 1
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         cy_in,
   input  logic         ac_in,
   input  logic         ov_in,
   output logic [W-1:0] res,
   output logic [W-1:0] res_hi,
   output logic         res_we,
   output logic         cy_out,
   output logic         ac_out,
   output logic         ov_out
);
   import acc_alu_pkg::*;

   localparam int HALF = W / 2;

   generate
      if (W < 8 || (W % NIB) != 0) begin : g_bad_width
         $error("acc_alu: W must be a multiple of 4 and at least 8");
      end
      if (DIV_IMPL != 0 && DIV_IMPL != 1) begin : g_bad_div
         $error("acc_alu: DIV_IMPL must be 0 or 1");
      end
   endgenerate

   alu_op_e opc;
   assign opc = alu_op_e'(op);

   logic          is_sub;
   logic          add_cin;
   logic [W-1:0]  add_sum;
   logic          add_c, add_h, add_v;

   assign is_sub  = (opc == OP_SUBB) || (opc == OP_CMP);
   assign add_cin = (opc == OP_ADDC || opc == OP_SUBB) ? cy_in : 1'b0;

   acc_alu_adder #(.W(W)) u_adder (
      .a     (opa),
      .b     (opb),
      .cin   (add_cin),
      .sub   (is_sub),
      .sum   (add_sum),
      .c_out (add_c),
      .h_out (add_h),
      .v_out (add_v)
   );

   logic [W-1:0] p_lo, p_hi, q, r;

   acc_alu_muldiv #(.W(W), .DIV_IMPL(DIV_IMPL)) u_muldiv (
      .a       (opa),
      .b       (opb),
      .prod_lo (p_lo),
      .prod_hi (p_hi),
      .quot    (q),
      .rem     (r)
   );

   logic [W-1:0] da_res;
   logic         da_cy;

   acc_alu_bcd #(.W(W)) u_bcd (
      .a      (opa),
      .cy_in  (cy_in),
      .ac_in  (ac_in),
      .res    (da_res),
      .cy_out (da_cy)
   );

   always_comb begin
      res    = '0;
      res_hi = '0;
      res_we = 1'b1;
      cy_out = cy_in;
      ac_out = ac_in;
      ov_out = ov_in;
      unique case (opc)
         OP_ADD, OP_ADDC, OP_SUBB: begin
            res    = add_sum;
            cy_out = add_c;
            ac_out = add_h;
            ov_out = add_v;
         end
         OP_INC:  res = opa + W'(1);
         OP_DEC:  res = opa - W'(1);
         OP_CMP: begin
            res_we = 1'b0;
            cy_out = add_c;
         end
         OP_MUL: begin
            res    = p_lo;
            res_hi = p_hi;
            cy_out = 1'b0;
            ov_out = |p_hi;
         end
         OP_DIV: begin
            res    = q;
            res_hi = r;
            cy_out = 1'b0;
            ov_out = (opb == '0);
         end
         OP_DA: begin
            res    = da_res;
            cy_out = da_cy;
         end
         OP_AND:  res = opa & opb;
         OP_OR:   res = opa | opb;
         OP_XOR:  res = opa ^ opb;
         OP_CPL:  res = ~opa;
         OP_RL:   res = {opa[W-2:0], opa[W-1]};
         OP_RR:   res = {opa[0], opa[W-1:1]};
         OP_SWAP: res = {opa[HALF-1:0], opa[W-1:HALF]};
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int W = 8
) (
   input logic [3:0]   op,
   input logic [W-1:0] opa,
   input logic [W-1:0] opb,
   input logic         cy_in,
   input logic         ac_in,
   input logic         ov_in,
   input logic [W-1:0] res,
   input logic [W-1:0] res_hi,
   input logic         res_we,
   input logic         cy_out,
   input logic         ac_out,
   input logic         ov_out
);
   always_comb begin
      if (op == 4'd0) begin
         assert_add_sum_R1: assert ({cy_out, res} == {1'b0, opa} + {1'b0, opb})
            else $error("add sum/carry mismatch");
      end
      if (op == 4'd3 || op == 4'd4) begin
         assert_incdec_flags_R3: assert (cy_out == cy_in && ac_out == ac_in && ov_out == ov_in)
            else $error("inc/dec changed a flag");
      end
      if (op == 4'd5) begin
         assert_cmp_nowrite_R4: assert (!res_we && ac_out == ac_in && ov_out == ov_in)
            else $error("compare wrote result or altered ac/ov");
      end
      if (op == 4'd6) begin
         assert_mul_flags_R5: assert (!cy_out && (ov_out == (res_hi != '0)))
            else $error("multiply flags inconsistent with high word");
      end
      if (op == 4'd7 && opb != '0) begin
         assert_div_identity_R6: assert ((res_hi < opb) &&
               ({{W{1'b0}}, res} * {{W{1'b0}}, opb} + {{W{1'b0}}, res_hi} == {{W{1'b0}}, opa})
               && !ov_out && !cy_out)
            else $error("divide identity broken");
      end
      if (op == 4'd7 && opb == '0) begin
         assert_div_zero_R6: assert (ov_out && !cy_out)
            else $error("zero divisor flags wrong");
      end
      if (op >= 4'd9) begin
         assert_logic_flags_R8: assert (cy_out == cy_in && ac_out == ac_in && ov_out == ov_in)
            else $error("logic/rotate changed a flag");
      end
      if (op != 4'd6 && op != 4'd7) begin
         assert_hi_zero_R10: assert (res_hi == '0)
            else $error("secondary result nonzero");
      end
   end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

   localparam int W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [3:0]   op;
   logic [W-1:0] opa, opb;
   logic         cy_in, ac_in, ov_in;
   logic [W-1:0] res, res_hi;
   logic         res_we, cy_out, ac_out, ov_out;

   acc_alu #(.W(W), .DIV_IMPL(1)) dut (
      .op(op), .opa(opa), .opb(opb),
      .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
      .res(res), .res_hi(res_hi), .res_we(res_we),
      .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // Packed expectation: res, res_hi, we, cy, ac, ov
   typedef struct packed {
      logic [7:0] r;
      logic [7:0] h;
      logic       we;
      logic       cy;
      logic       ac;
      logic       ov;
   } exp_t;

   function automatic string req_of(int o);
      case (o)
         0, 1:           return "R1";
         2:              return "R2";
         3, 4:           return "R3";
         5:              return "R4";
         6:              return "R5";
         7:              return "R6";
         8:              return "R7";
         9, 10, 11, 12:  return "R8";
         default:        return "R9";
      endcase
   endfunction

   function automatic int sx(int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   // Returns expectation; mask selects which fields are defined.
   function automatic exp_t model(int o, int a, int b, bit c, bit h, bit v, output exp_t msk);
      exp_t e;
      int t, s;
      e = '0; e.we = 1; e.cy = c; e.ac = h; e.ov = v;
      msk = '1;
      case (o)
         0, 1: begin
            int ci = (o == 1) ? int'(c) : 0;
            t = a + b + ci;
            e.r = t[7:0]; e.cy = t > 255;
            e.ac = ((a % 16) + (b % 16) + ci) > 15;
            s = sx(a) + sx(b) + ci;
            e.ov = (s > 127) || (s < -128);
         end
         2: begin
            t = a - b - int'(c);
            e.r = 8'(t & 255); e.cy = t < 0;
            e.ac = ((a % 16) - (b % 16) - int'(c)) < 0;
            s = sx(a) - sx(b) - int'(c);
            e.ov = (s > 127) || (s < -128);
         end
         3: e.r = 8'((a + 1) % 256);
         4: e.r = 8'((a + 255) % 256);
         5: begin e.we = 0; e.cy = a < b; msk.r = '0; end
         6: begin t = a * b; e.r = t[7:0]; e.h = t[15:8]; e.cy = 0; e.ov = t > 255; end
         7: begin
            e.cy = 0;
            if (b == 0) begin e.ov = 1; msk.r = '0; msk.h = '0; end
            else begin e.r = 8'(a / b); e.h = 8'(a % b); e.ov = 0; end
         end
         8: begin
            bit c1, c2;
            t = a;
            if ((t % 16) > 9 || h) t = t + 6;
            c1 = t > 255; t = t % 256;
            if ((t / 16) > 9 || c || c1) t = t + 96;
            c2 = t > 255;
            e.r = 8'(t % 256); e.cy = c | c1 | c2;
         end
         9:  e.r = 8'(a & b);
         10: e.r = 8'(a | b);
         11: e.r = 8'(a ^ b);
         12: e.r = 8'(255 - a);
         13: e.r = 8'(((a * 2) % 256) + (a / 128));
         14: e.r = 8'((a / 2) + (a % 2) * 128);
         default: e.r = 8'((a % 16) * 16 + (a / 16));
      endcase
      return e;
   endfunction

   task automatic apply(int o, int a, int b, bit c, bit h, bit v);
      exp_t e, m, got;
      @(negedge clk);
      op = 4'(o); opa = 8'(a); opb = 8'(b); cy_in = c; ac_in = h; ov_in = v;
      @(posedge clk);
      #1;
      e   = model(o, a, b, c, h, v, m);
      got = {res, res_hi, res_we, cy_out, ac_out, ov_out};
      n_checks++;
      if ((got & m) !== (e & m)) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%02h b=%02h ci=%b%b%b actual=%h expected=%h",
                  req_of(o), o, a, b, c, h, v, got & m, e & m);
      end
   endtask

   task automatic check_r10(int o);
      n_checks++;
      if (res_we !== (o != 5) || ((o != 6 && o != 7) && res_hi !== 8'h00)) begin
         n_fail++;
         $display("FAIL R10 op=%0d actual we=%b hi=%02h expected we=%b hi=00",
                  o, res_we, res_hi, o != 5);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      op = '0; opa = '0; opb = '0; cy_in = 0; ac_in = 0; ov_in = 0;
      void'($urandom(32'd2024));
      // Idle-state check: zero operands with add give zero everywhere (R1)
      apply(0, 0, 0, 0, 0, 0);
      // R1 directed: carry out, aux carry, signed overflow
      apply(0, 8'hFF, 8'h01, 0, 0, 0);
      apply(0, 8'h7F, 8'h01, 0, 0, 0);
      apply(1, 8'h0F, 8'h00, 1, 0, 0);
      apply(1, 8'h80, 8'h80, 1, 0, 0);
      // R2 directed: borrow, borrow-in, overflow
      apply(2, 8'h00, 8'h01, 0, 0, 0);
      apply(2, 8'h10, 8'h00, 1, 0, 0);
      apply(2, 8'h80, 8'h01, 0, 0, 0);
      // R3 wrap
      apply(3, 8'hFF, 0, 1, 1, 1);
      apply(4, 8'h00, 0, 0, 1, 0);
      // R4 compare edges
      apply(5, 8'h10, 8'h11, 0, 1, 1);
      apply(5, 8'h11, 8'h11, 1, 0, 1);
      // R5 product fits / overflows
      apply(6, 8'h0F, 8'h11, 1, 1, 1);
      apply(6, 8'hFF, 8'hFF, 1, 0, 0);
      // R6 normal and zero divisor
      apply(7, 8'hFB, 8'h12, 1, 1, 0);
      apply(7, 8'h37, 8'h00, 1, 0, 0);
      apply(7, 8'h05, 8'h09, 0, 0, 1);
      // R7 decimal adjust corners
      apply(8, 8'h9A, 0, 0, 0, 0);
      apply(8, 8'h00, 0, 1, 1, 0);
      apply(8, 8'hFA, 0, 0, 0, 0);
      apply(8, 8'h45, 0, 0, 0, 1);
      // R8 / R9 with flags set
      apply(12, 8'hA5, 0, 1, 1, 1);
      apply(13, 8'h81, 0, 1, 0, 1);
      apply(14, 8'h01, 0, 0, 1, 0);
      apply(15, 8'h3C, 0, 1, 1, 1);
      // R10 strobe and secondary word, every op
      for (int o = 0; o < 16; o++) begin
         apply(o, 8'hC3, 8'h5A, 0, 1, 0);
         check_r10(o);
      end
      // Constrained random: bias some operands to edges
      for (int i = 0; i < 3000; i++) begin
         int o, a, b, sel;
         o   = int'($urandom_range(15, 0));
         sel = int'($urandom_range(7, 0));
         a   = (sel == 0) ? 255 : int'($urandom_range(255, 0));
         b   = (sel == 1) ? 0 : (sel == 2) ? 255 : int'($urandom_range(255, 0));
         apply(o, a, b, 1'($urandom), 1'($urandom), 1'($urandom));
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule